// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Majority-Voted LSB

This block is the digital controller of a 10-bit successive-approximation converter that is followed by a second-order noise-shaping loop. The analog DAC, the comparator and the integration capacitors sit outside it. The block only drives their control pins and reads one comparator decision per strobe. After the active-low reset is released, every conversion opens with a one-cycle input sample. Nine binary-search trials resolve the upper bits, starting from the mid-scale code. The least significant bit is then decided by a majority over three comparator strobes taken at one unchanged DAC code. This suppresses comparator noise on the bit that the noise-shaping loop depends on most.

Once the last bit is known, the block pulses a done strobe. It loads the parallel result and holds the final code on the DAC so the residue can be sampled. It then issues three one-cycle phase pulses in a fixed order: residue sample, first integration, second integration. An idle cycle separates the pulses. The next input sample follows the second-integration pulse at once, so conversions repeat every 30 clock cycles. Each decided bit is also presented serially, MSB first, in the low half of the comparator strobe period.

Top module: `sarseq_top`

## Requirements
- R1: While `rstN` is low, every pulse output, `resultValid` and `result` read 0, `dacP` reads the mid-scale code 512 (bit 9 set) and `dacN` reads 511.
- R2: In the first clock cycle after `rstN` rises, `sampleEn` is high for exactly one cycle, and no other phase output is high in that cycle.
- R3: Each comparator strobe `cmpClk` is high for one cycle and low for the following cycle. The decision on `cmpIn` is taken at the clock edge that ends the high cycle, and `dacP` does not change during a high cycle.
- R4: The first trial code is 512. For bit i from 9 down to 1, `cmpIn`=1 (input at or above the code) keeps bit i at 1 and `cmpIn`=0 clears it. Either way, bit i-1 is set as the next trial, so the code changes 9 times before the LSB trial.
- R5: The LSB is compared three times at one code (bits 9..1 resolved, bit 0 set), and bit 0 of the result takes the value held by at least two of the three `cmpIn` samples.
- R6: `serValid` pulses in the low cycle after each bit decision, ten pulses per conversion in the order bit 9 down to bit 0, with `serBit` carrying the bit. The bit 0 pulse coincides with `convDone`.
- R7: `convDone` is a one-cycle pulse, 24 cycles after the sample cycle. `result` and `resultValid`=1 take their new values in that same cycle, and `result` does not change at any other time.
- R8: `dacN` is always the bitwise complement of `dacP`. From the `convDone` cycle through the second-integration pulse, `dacP` holds the converted result, and it returns to 512 for the sample cycle.
- R9: The cycle after `convDone` raises `nsSample`. Then come one idle cycle, `nsInt1`, one idle cycle and `nsInt2`, each one cycle wide, with no two phase outputs high together.
- R10: `sampleEn` rises in the cycle right after `nsInt2` and never earlier, so back-to-back conversions have a 30-cycle period.
- R11: Pulling `rstN` low in the middle of a conversion aborts it, returns the outputs to the R1 state, and a complete conversion starts with a sample cycle right after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpIn | input | 1 | Comparator decision, 1 when input is at or above the DAC code |
| sampleEn | output | 1 | Input sampling phase |
| cmpClk | output | 1 | Comparator strobe |
| dacP | output | 10 | Positive-side DAC code |
| dacN | output | 10 | Negative-side DAC code, complement of dacP |
| serBit | output | 1 | Serial result bit, MSB first |
| serValid | output | 1 | Qualifies serBit |
| convDone | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Parallel conversion result |
| resultValid | output | 1 | Set once the first result is loaded |
| nsSample | output | 1 | Residue-sample phase pulse |
| nsInt1 | output | 1 | First-integration phase pulse |
| nsInt2 | output | 1 | Second-integration phase pulse |

## Verification
The final LSB vote, the serial bit 0 pulse, the done strobe and the parallel result load all fall in the same cycle, and the mid-scale reload of the DAC coincides with the last phase pulse. To provoke disagreement at the vote, the bench comparator is overridden during the three LSB strobes with split patterns such as 1-0-1 and 0-1-0, whose majority differs from what the held input alone would give. The bench then checks in that one cycle that `serBit`, bit 0 of `result`, bit 0 of `dacP` and `convDone` agree with its own majority. It also checks that the DAC and `sampleEn` change in the cycle right after `nsInt2`.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

  // controller state; each comparison is a strobe-high and a strobe-low cycle
  typedef enum logic [2:0] {
    ST_SAMPLE = 3'd0,
    ST_CMPH   = 3'd1,
    ST_CMPL   = 3'd2,
    ST_NSS    = 3'd3,
    ST_GAP1   = 3'd4,
    ST_NS1    = 3'd5,
    ST_GAP2   = 3'd6,
    ST_NS2    = 3'd7
  } seqState_t;

  // strobes from control to datapath, all valid in a single cycle
  typedef struct packed {
    logic takeBit;   // resolve the bit selected by bitIdx from cmpIn
    logic takeVote;  // store one LSB vote
    logic lastVote;  // final LSB vote: resolve bit 0 and publish
    logic reload;    // return the DAC code to mid-scale
  } seqCtl_t;

  function automatic int unsigned countOnes(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int VOTES = 3,
  localparam int CNTW = $clog2(WIDTH + 1),
  localparam int IDXW = $clog2(WIDTH),
  localparam int VCW  = $clog2(VOTES)
) (
  input  logic            clk,
  input  logic            rstN,
  output seqCtl_t         ctl,
  output logic [IDXW-1:0] bitIdx,
  output logic            sampleRaw,
  output logic            cmpClk,
  output logic            nsSample,
  output logic            nsInt1,
  output logic            nsInt2
);

  seqState_t       state, nextState;
  logic [CNTW-1:0] bitCnt;
  logic [VCW-1:0]  voteCnt;
  logic            convEnd;
  logic [CNTW-1:0] idxWide;

  // bit counter runs 1..WIDTH; counter value n selects bit WIDTH-n
  assign idxWide = CNTW'(WIDTH) - bitCnt;
  assign bitIdx  = idxWide[IDXW-1:0];

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_SAMPLE: nextState = ST_CMPH;
      ST_CMPH: begin
        nextState = ST_CMPL;
        if (bitCnt != CNTW'(WIDTH)) begin
          ctl.takeBit = 1'b1;
        end else begin
          ctl.takeVote = 1'b1;
          ctl.lastVote = (voteCnt == VCW'(VOTES - 1));
        end
      end
      ST_CMPL: nextState = convEnd ? ST_NSS : ST_CMPH;
      ST_NSS:  nextState = ST_GAP1;
      ST_GAP1: nextState = ST_NS1;
      ST_NS1:  nextState = ST_GAP2;
      ST_GAP2: nextState = ST_NS2;
      ST_NS2: begin
        ctl.reload = 1'b1;
        nextState  = ST_SAMPLE;
      end
      default: nextState = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SAMPLE;
      bitCnt  <= CNTW'(1);
      voteCnt <= '0;
      convEnd <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.takeBit) bitCnt <= bitCnt + CNTW'(1);
      else if (ctl.lastVote) bitCnt <= CNTW'(1);
      if (ctl.lastVote) voteCnt <= '0;
      else if (ctl.takeVote) voteCnt <= voteCnt + VCW'(1);
      if (ctl.lastVote) convEnd <= 1'b1;
      else if (state == ST_NSS) convEnd <= 1'b0;
    end
  end

  assign sampleRaw = (state == ST_SAMPLE);
  assign cmpClk    = (state == ST_CMPH);
  assign nsSample  = (state == ST_NSS);
  assign nsInt1    = (state == ST_NS1);
  assign nsInt2    = (state == ST_NS2);

endmodule

// File: rtl/sarseq_dpath.sv
module sarseq_dpath
  import sarseq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int VOTES = 3,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] code,
  output logic             serBit,
  output logic             serValid,
  output logic             convDone,
  output logic [WIDTH-1:0] result,
  output logic             resultValid
);

  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

  logic [VOTES-2:0] voteSh;
  logic [VOTES-1:0] voteAll;
  logic             voteMaj;
  logic [WIDTH-1:0] codeNext;

  assign voteAll = {voteSh, cmpIn};
  assign voteMaj = countOnes(32'(voteAll)) > (VOTES / 2);

  // per-bit next code: resolve the selected bit, arm the one below it
  for (genvar i = 0; i < WIDTH; i++) begin : g_codeBit
    logic selHere, selAbove;
    assign selHere = ctl.takeBit && (bitIdx == IDXW'(i));
    if (i < WIDTH - 1) begin : g_arm
      assign selAbove = ctl.takeBit && (bitIdx == IDXW'(i + 1));
    end else begin : g_top
      assign selAbove = 1'b0;
    end
    if (i == 0) begin : g_lsb
      assign codeNext[i] = ctl.reload   ? MID[i]  :
                           ctl.lastVote ? voteMaj :
                           selAbove     ? 1'b1    :
                           selHere      ? cmpIn   : code[i];
    end else begin : g_upper
      assign codeNext[i] = ctl.reload ? MID[i] :
                           selAbove   ? 1'b1   :
                           selHere    ? cmpIn  : code[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code        <= MID;
      voteSh      <= '0;
      serBit      <= 1'b0;
      serValid    <= 1'b0;
      convDone    <= 1'b0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      code     <= codeNext;
      serValid <= ctl.takeBit | ctl.lastVote;
      convDone <= ctl.lastVote;
      if (ctl.takeBit) serBit <= cmpIn;
      else if (ctl.lastVote) serBit <= voteMaj;
      if (ctl.takeVote) voteSh <= voteAll[VOTES-2:0];
      if (ctl.lastVote) begin
        result      <= {code[WIDTH-1:1], voteMaj};
        resultValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sarseq_top.sv
module sarseq_top
  import sarseq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int VOTES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  output logic             sampleEn,
  output logic             cmpClk,
  output logic [WIDTH-1:0] dacP,
  output logic [WIDTH-1:0] dacN,
  output logic             serBit,
  output logic             serValid,
  output logic             convDone,
  output logic [WIDTH-1:0] result,
  output logic             resultValid,
  output logic             nsSample,
  output logic             nsInt1,
  output logic             nsInt2
);

  localparam int IDXW = $clog2(WIDTH);

  seqCtl_t         ctl;
  logic [IDXW-1:0] bitIdx;
  logic            sampleRaw;
  logic [WIDTH-1:0] code;

  sarseq_ctrl #(.WIDTH(WIDTH), .VOTES(VOTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx),
    .sampleRaw(sampleRaw), .cmpClk(cmpClk),
    .nsSample(nsSample), .nsInt1(nsInt1), .nsInt2(nsInt2)
  );

  sarseq_dpath #(.WIDTH(WIDTH), .VOTES(VOTES)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx), .cmpIn(cmpIn),
    .code(code), .serBit(serBit), .serValid(serValid), .convDone(convDone),
    .result(result), .resultValid(resultValid)
  );

  // sampling is held off while reset is asserted
  assign sampleEn = sampleRaw & rstN;
  assign dacP     = code;
  assign dacN     = ~code;

endmodule

// File: rtl/sarseq_chk.sv
module sarseq_chk #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleEn,
  input logic             cmpClk,
  input logic [WIDTH-1:0] dacP,
  input logic             serValid,
  input logic             convDone,
  input logic [WIDTH-1:0] result,
  input logic             resultValid,
  input logic             nsSample,
  input logic             nsInt1,
  input logic             nsInt2
);

  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (!rstN) cmpClk |=> !cmpClk); // R3
  AST_CMP_DAC_STABLE: assert property (@(posedge clk) disable iff (!rstN) cmpClk |-> $stable(dacP)); // R3
  AST_SER_LOW: assert property (@(posedge clk) disable iff (!rstN) serValid |-> !cmpClk); // R6
  AST_DONE_SER: assert property (@(posedge clk) disable iff (!rstN) convDone |-> serValid); // R6
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rstN) convDone |-> resultValid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN) !convDone |-> $stable(result)); // R7
  AST_DAC_RESULT: assert property (@(posedge clk) disable iff (!rstN) nsSample |-> (dacP == result)); // R8
  AST_DONE_NS: assert property (@(posedge clk) disable iff (!rstN) convDone |=> nsSample); // R9
  AST_NS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleEn, cmpClk, nsSample, nsInt1, nsInt2})); // R9
  AST_NS_ORDER1: assert property (@(posedge clk) disable iff (!rstN) nsSample |-> ##2 nsInt1); // R9
  AST_NS_ORDER2: assert property (@(posedge clk) disable iff (!rstN) nsInt1 |-> ##2 nsInt2); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN) nsInt2 |=> sampleEn); // R10

endmodule

bind sarseq_top sarseq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .cmpClk(cmpClk), .dacP(dacP),
  .serValid(serValid), .convDone(convDone), .result(result),
  .resultValid(resultValid), .nsSample(nsSample), .nsInt1(nsInt1), .nsInt2(nsInt2)
);

// File: tb/sarseq_tb.sv
module sarseq_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpIn = 1'b0;
  logic       sampleEn, cmpClk, serBit, serValid, convDone, resultValid;
  logic       nsSample, nsInt1, nsInt2;
  logic [9:0] dacP, dacN, result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int vin;
  bit useOvr;
  bit [2:0] pat;
  int expResQ;
  int expValidQ;

  always #2.5 clk = ~clk;

  sarseq_top dut_i (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .sampleEn(sampleEn), .cmpClk(cmpClk),
    .dacP(dacP), .dacN(dacN), .serBit(serBit), .serValid(serValid),
    .convDone(convDone), .result(result), .resultValid(resultValid),
    .nsSample(nsSample), .nsInt1(nsInt1), .nsInt2(nsInt2)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int trial(input int v, input int i);
    return ((v >> (i + 1)) << (i + 1)) | (1 << i);
  endfunction

  function automatic int finalOf();
    int maj;
    if (useOvr) maj = (int'(pat[0]) + int'(pat[1]) + int'(pat[2]) >= 2) ? 1 : 0;
    else maj = vin & 1;
    return (vin & 1022) | maj;
  endfunction

  task automatic checkReset(input string req);
    chk(req, "sampleEn", sampleEn, 0);
    chk(req, "cmpClk", cmpClk, 0);
    chk(req, "serValid", serValid, 0);
    chk(req, "convDone", convDone, 0);
    chk(req, "resultValid", resultValid, 0);
    chk(req, "result", result, 0);
    chk(req, "dacP", dacP, 512);
    chk(req, "dacN", dacN, 511);
    chk(req, "ns pulses", {nsSample, nsInt1, nsInt2}, 0);
  endtask

  // compare all outputs in cycle t of a conversion, then drive cmpIn
  task automatic checkCycle(input int t, input string sampReq);
    int expCode, fin;
    string dacReq, resReq;
    fin = finalOf();
    if (t == 24) begin expResQ = fin; expValidQ = 1; end
    if (t == 0) expCode = 512;
    else if (t <= 18) expCode = trial(vin, 9 - t / 2);
    else if (t <= 23) expCode = trial(vin, 0);
    else expCode = fin;
    dacReq = (t >= 1 && t <= 18) ? "R4" : (t >= 19 && t <= 23) ? "R5" : "R8";
    resReq = (useOvr && t >= 24) ? "R5" : "R7";
    chk(sampReq, "sampleEn", sampleEn, (t == 0) ? 1 : 0);
    chk("R3", "cmpClk", cmpClk, (t % 2 == 1 && t <= 23) ? 1 : 0);
    chk(dacReq, "dacP", dacP, expCode);
    chk("R8", "dacN", dacN, (~expCode) & 1023);
    if ((t % 2 == 0 && t >= 2 && t <= 18) || t == 24) begin
      chk("R6", "serValid", serValid, 1);
      chk((t == 24) ? resReq : "R6", "serBit", serBit,
          (t == 24) ? (fin & 1) : ((vin >> (10 - t / 2)) & 1));
    end else begin
      chk("R6", "serValid", serValid, 0);
    end
    chk("R7", "convDone", convDone, (t == 24) ? 1 : 0);
    chk(resReq, "result", result, expResQ);
    chk("R7", "resultValid", resultValid, expValidQ);
    chk("R9", "nsSample", nsSample, (t == 25) ? 1 : 0);
    chk("R9", "nsInt1", nsInt1, (t == 27) ? 1 : 0);
    chk("R9", "nsInt2", nsInt2, (t == 29) ? 1 : 0);
    if (t % 2 == 1 && t <= 17) cmpIn = (vin >= trial(vin, 9 - t / 2));
    else if (t % 2 == 1 && t >= 19 && t <= 23)
      cmpIn = useOvr ? pat[(t - 19) / 2] : (vin >= trial(vin, 0));
    else cmpIn = 1'b0;
  endtask

  task automatic runConv(input int v, input bit ovr, input bit [2:0] p,
                         input string sampReq, input int abortAt);
    vin = v; useOvr = ovr; pat = p;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      checkCycle(t, sampReq);
      if (t == abortAt) begin
        rstN = 1'b0;
        expResQ = 0; expValidQ = 0;
        return;
      end
    end
  endtask

  initial begin
    int vins[11] = '{0, 1023, 512, 511, 341, 682, 1, 1022, 700, 701, 300};
    expResQ = 0; expValidQ = 0;
    repeat (3) begin @(negedge clk); checkReset("R1"); end
    @(posedge clk); #1 rstN = 1'b1;
    runConv(vins[0], 0, 3'b000, "R2", -1);
    for (int k = 1; k < 11; k++) runConv(vins[k], 0, 3'b000, "R10", -1);
    // split LSB votes against the natural answer (R5)
    runConv(700, 1, 3'b101, "R10", -1);
    runConv(701, 1, 3'b010, "R10", -1);
    runConv(700, 1, 3'b011, "R10", -1);
    runConv(701, 1, 3'b100, "R10", -1);
    // abort in mid-conversion (R11)
    runConv(300, 0, 3'b000, "R10", 10);
    repeat (3) begin @(negedge clk); checkReset("R11"); end
    @(posedge clk); #1 rstN = 1'b1;
    runConv(300, 0, 3'b000, "R11", -1);
    runConv(853, 1, 3'b110, "R10", -1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule